// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank with Update Timer

This block keeps a set of byte-wide configuration registers in two copies. The host copy is written from a host-side port on its own clock, and those writes can arrive at any time, even while the system clock is stopped. The working copy feeds the downstream datapath. It changes only when an update event, sampled on the system clock, copies the whole host copy across in one edge. Because of this, a multi-byte setting never reaches the datapath half written.

An update event has one of two sources, and a mode bit in the working copy chooses between them. In internal mode a counter produces an event every (period + 1) system clocks and drives a one-cycle pulse on the update pin. In external mode the update pin is an input, and after a two-flop synchroniser each rising edge on it produces one event. A synchronous active-high master reset loads the same default image into both copies. Two control bits drive the accumulator clear outputs. One is a one-shot that clears itself in the working copy only. The other is a level that holds both clears active.

Top module: `cfg_dbuf_bank`

## Requirements
- R1: A host write (h_we high at a rising edge of hclk, h_addr below 16) stores h_wdata into host byte h_addr and leaves the working copy (active_o, byte k at bits 8k+7:8k) unchanged until the next update event.
- R2: On an update event, every byte of active_o takes the value of the matching host byte at the same rising edge of sys_clk.
- R3: While the mode bit is 1, an update event occurs every P+1 sys_clk cycles, where P is the 32-bit little-endian value in working bytes 0..3. upd_pin_o is high for the one cycle after each such event.
- R4: upd_pin_oe equals the mode bit, which is bit 0 of working byte 5 (control word bit 8). upd_pin_o is only ever high one cycle after upd_pin_oe was high.
- R5: While the mode bit is 0, upd_pin_i rising before sys_clk edge E1 causes the working copy to load at edge E3, the third rising edge. Pin edges have no effect while the mode bit is 1.
- R6: While rst is high at a clock edge, both copies load defaults: byte 0 = 0x40, byte 4 = 0x20, byte 5 = 0x01, byte 6 = 0x64, byte 7 = 0x10, all other bytes 0. The block therefore starts in internal mode with P = 64.
- R7: A change to the mode bit in the host copy has no effect on the update source or on upd_pin_oe until an update event moves it into the working copy.
- R8: The one-shot bit (bit 7 of byte 5, control bit 15) loaded as 1 raises clr_acc1_o for exactly one sys_clk cycle and then reads 0 in the working copy. The host copy keeps the 1, so each later update pulses again.
- R9: While the hold bit (bit 6 of byte 5, control bit 14) is 1 in the working copy, clr_acc1_o and clr_acc2_o are both high.
- R10: Host writes with h_addr of 16 or more change no byte of either copy.
- R11: Host writes made while sys_clk is stopped are kept and reach the working copy at the first update after the clock restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the working copy and update logic |
| rst | input | 1 | Master reset, synchronous, active high |
| hclk | input | 1 | Host-side clock for the host copy |
| h_we | input | 1 | Host write strobe |
| h_addr | input | 5 | Host byte address |
| h_wdata | input | 8 | Host write data |
| upd_pin_i | input | 1 | Update pin level seen from outside |
| upd_pin_o | output | 1 | Update pin value driven in internal mode |
| upd_pin_oe | output | 1 | Update pin output enable (1 = driven) |
| active_o | output | 128 | Working copy, byte k at bits 8k+7:8k |
| clr_acc1_o | output | 1 | Accumulator 1 clear |
| clr_acc2_o | output | 1 | Accumulator 2 clear |

## Verification
If the working copy ever loads outside an event, active_o is wrong at the very next sys_clk edge. If the period counter drifts, upd_pin_o pulses come at the wrong spacing and the working copy changes out of step. Both therefore show within one period of the fault. A one-shot bit that does not clear leaves clr_acc1_o high a second cycle, and a mode bit taken from the host copy flips upd_pin_oe before its event. The bench compares every output against its reference on every cycle, so any of these faults is caught in the cycle it first appears.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

  // control word bit positions (control word = 4 bytes, little endian)
  localparam int CTRL_MODE_BIT = 8;
  localparam int CTRL_HOLD_BIT = 14;
  localparam int CTRL_OS_BIT   = 15;

  // default value of one byte of the bank image
  function automatic logic [7:0] reset_byte(input int idx, input int rate_base,
                                            input int ctrl_base,
                                            input logic [31:0] rate_dflt,
                                            input logic [31:0] ctrl_dflt);
    logic [7:0] v;
    v = 8'h00;
    if (idx >= rate_base && idx < rate_base + 4)
      v = rate_dflt[8*(idx-rate_base) +: 8];
    else if (idx >= ctrl_base && idx < ctrl_base + 4)
      v = ctrl_dflt[8*(idx-ctrl_base) +: 8];
    return v;
  endfunction

endpackage

// File: rtl/cfg_host_buffer.sv
module cfg_host_buffer #(
  parameter int          NBYTES    = 16,
  parameter int          ADDR_W    = 5,
  parameter int          RATE_BASE = 0,
  parameter int          CTRL_BASE = 4,
  parameter logic [31:0] RATE_DFLT = 32'h0000_0040,
  parameter logic [31:0] CTRL_DFLT = 32'h1064_0120
) (
  input  logic                  hclk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            wdata,
  output logic [NBYTES*8-1:0]   buf_q
);
  logic [NBYTES-1:0][7:0] bytes_q;

  always_ff @(posedge hclk) begin
    for (int i = 0; i < NBYTES; i++) begin
      if (rst)
        bytes_q[i] <= cfgbank_pkg::reset_byte(i, RATE_BASE, CTRL_BASE, RATE_DFLT, CTRL_DFLT);
      else if (we && int'(addr) == i)
        bytes_q[i] <= wdata;
    end
  end

  assign buf_q = bytes_q;
endmodule

// File: rtl/cfg_update_gen.sv
module cfg_update_gen #(
  parameter int RATE_W = 32
) (
  input  logic              sys_clk,
  input  logic              rst,
  input  logic              mode_int,
  input  logic [RATE_W-1:0] rate,
  input  logic              pin_i,
  output logic              fire,
  output logic              pin_o
);
  logic              s1_q, s2_q, s3_q;
  logic [RATE_W-1:0] cnt_q;
  logic              fire_int, ext_edge;

  assign fire_int = mode_int && (cnt_q >= rate);
  assign ext_edge = s2_q && !s3_q;
  assign fire     = mode_int ? fire_int : ext_edge;

  always_ff @(posedge sys_clk) begin
    if (rst) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
      cnt_q <= '0;
      pin_o <= 1'b0;
    end else begin
      s1_q  <= pin_i;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      pin_o <= fire_int;
      if (!mode_int || fire_int) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5
  ext_fire_chk: assert property (@(posedge sys_clk) disable iff (rst)
    (fire && !mode_int) |-> $past(pin_i, 2));
endmodule

// File: rtl/cfg_active_bank.sv
module cfg_active_bank #(
  parameter int          NBYTES    = 16,
  parameter int          RATE_BASE = 0,
  parameter int          CTRL_BASE = 4,
  parameter logic [31:0] RATE_DFLT = 32'h0000_0040,
  parameter logic [31:0] CTRL_DFLT = 32'h1064_0120
) (
  input  logic                sys_clk,
  input  logic                rst,
  input  logic                fire,
  input  logic [NBYTES*8-1:0] buf_d,
  output logic [NBYTES*8-1:0] act_q
);
  localparam int W      = NBYTES*8;
  localparam int OS_IDX = CTRL_BASE*8 + cfgbank_pkg::CTRL_OS_BIT;
  localparam logic [W-1:0] KEEP_MASK = ~(W'(1) << OS_IDX);

  always_ff @(posedge sys_clk) begin
    if (rst) begin
      for (int i = 0; i < NBYTES; i++)
        act_q[i*8 +: 8] <= cfgbank_pkg::reset_byte(i, RATE_BASE, CTRL_BASE, RATE_DFLT, CTRL_DFLT);
    end else if (fire) begin
      act_q <= buf_d;
    end else begin
      act_q[OS_IDX] <= 1'b0;
    end
  end

  // R1
  hold_chk: assert property (@(posedge sys_clk) disable iff (rst)
    !fire |=> ((act_q & KEEP_MASK) == ($past(act_q) & KEEP_MASK)));

  // R8
  oneshot_chk: assert property (@(posedge sys_clk) disable iff (rst)
    act_q[OS_IDX] |=> (!act_q[OS_IDX] || $past(fire)));
endmodule

// File: rtl/cfg_dbuf_bank.sv
module cfg_dbuf_bank #(
  parameter int          NBYTES    = 16,
  parameter int          ADDR_W    = 5,
  parameter int          RATE_W    = 32,
  parameter int          RATE_BASE = 0,
  parameter int          CTRL_BASE = 4,
  parameter logic [31:0] RATE_DFLT = 32'h0000_0040,
  parameter logic [31:0] CTRL_DFLT = 32'h1064_0120
) (
  input  logic                sys_clk,
  input  logic                rst,
  input  logic                hclk,
  input  logic                h_we,
  input  logic [ADDR_W-1:0]   h_addr,
  input  logic [7:0]          h_wdata,
  input  logic                upd_pin_i,
  output logic                upd_pin_o,
  output logic                upd_pin_oe,
  output logic [NBYTES*8-1:0] active_o,
  output logic                clr_acc1_o,
  output logic                clr_acc2_o
);
  localparam int MODE_IDX = CTRL_BASE*8 + cfgbank_pkg::CTRL_MODE_BIT;
  localparam int HOLD_IDX = CTRL_BASE*8 + cfgbank_pkg::CTRL_HOLD_BIT;
  localparam int OS_IDX   = CTRL_BASE*8 + cfgbank_pkg::CTRL_OS_BIT;

  logic [NBYTES*8-1:0] buf_w;
  logic [NBYTES*8-1:0] act_w;
  logic                fire_w;
  logic                mode_int;

  cfg_host_buffer #(
    .NBYTES(NBYTES), .ADDR_W(ADDR_W), .RATE_BASE(RATE_BASE),
    .CTRL_BASE(CTRL_BASE), .RATE_DFLT(RATE_DFLT), .CTRL_DFLT(CTRL_DFLT)
  ) u_host (
    .hclk(hclk), .rst(rst), .we(h_we), .addr(h_addr), .wdata(h_wdata), .buf_q(buf_w)
  );

  cfg_update_gen #(.RATE_W(RATE_W)) u_upd (
    .sys_clk(sys_clk), .rst(rst), .mode_int(mode_int),
    .rate(act_w[RATE_BASE*8 +: RATE_W]), .pin_i(upd_pin_i),
    .fire(fire_w), .pin_o(upd_pin_o)
  );

  cfg_active_bank #(
    .NBYTES(NBYTES), .RATE_BASE(RATE_BASE), .CTRL_BASE(CTRL_BASE),
    .RATE_DFLT(RATE_DFLT), .CTRL_DFLT(CTRL_DFLT)
  ) u_act (
    .sys_clk(sys_clk), .rst(rst), .fire(fire_w), .buf_d(buf_w), .act_q(act_w)
  );

  assign mode_int   = act_w[MODE_IDX];
  assign upd_pin_oe = mode_int;
  assign active_o   = act_w;
  assign clr_acc1_o = act_w[OS_IDX] | act_w[HOLD_IDX];
  assign clr_acc2_o = act_w[HOLD_IDX];

  // R4
  pin_dir_chk: assert property (@(posedge sys_clk) disable iff (rst)
    upd_pin_o |-> $past(upd_pin_oe));
endmodule

// File: tb/sim_cfg_dbuf_bank.sv
`timescale 1ns/100ps
module sim_cfg_dbuf_bank;
  localparam int NB = 16;

  logic sys_clk = 1'b0, hclk = 1'b0, clk_run = 1'b1;
  logic rst = 1'b1, h_we = 1'b0, upd_pin_i = 1'b0;
  logic [4:0] h_addr = '0;
  logic [7:0] h_wdata = '0;
  logic upd_pin_o, upd_pin_oe, clr_acc1_o, clr_acc2_o;
  logic [NB*8-1:0] active_o;

  int checks = 0, errors = 0;
  bit done = 0, started = 0;

  always #2.5 sys_clk = clk_run ? ~sys_clk : 1'b0;
  always #7   hclk = ~hclk;

  cfg_dbuf_bank u0 (
    .sys_clk(sys_clk), .rst(rst), .hclk(hclk), .h_we(h_we), .h_addr(h_addr),
    .h_wdata(h_wdata), .upd_pin_i(upd_pin_i), .upd_pin_o(upd_pin_o),
    .upd_pin_oe(upd_pin_oe), .active_o(active_o),
    .clr_acc1_o(clr_acc1_o), .clr_acc2_o(clr_acc2_o)
  );

  task automatic chk(input string req, input logic [NB*8-1:0] act, input logic [NB*8-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int dflt(input int i);
    case (i)
      0: return 'h40;
      4: return 'h20;
      5: return 'h01;
      6: return 'h64;
      7: return 'h10;
      default: return 0;
    endcase
  endfunction

  // ---------------- reference model ----------------
  int  bufm [NB];
  int  actm [NB];
  longint tick, ratem;
  bit  p1, p2, p3, pinm, modem, fim, fem;

  always @(posedge hclk) begin
    if (rst) begin
      for (int i = 0; i < NB; i++) bufm[i] = dflt(i);
    end else if (h_we && int'(h_addr) < NB) begin
      bufm[int'(h_addr)] = int'(h_wdata);
    end
  end

  always @(posedge sys_clk) begin
    started = 1;
    if (rst) begin
      for (int i = 0; i < NB; i++) actm[i] = dflt(i);
      tick = 0; p1 = 0; p2 = 0; p3 = 0; pinm = 0;
    end else begin
      modem = actm[5][0];
      ratem = longint'(actm[0]) + longint'(actm[1])*256 + longint'(actm[2])*65536
            + longint'(actm[3])*16777216;
      fim   = modem && (tick >= ratem);
      fem   = !modem && p2 && !p3;
      pinm  = fim;
      tick  = (!modem || fim) ? 0 : tick + 1;
      p3 = p2; p2 = p1; p1 = upd_pin_i;
      if (fim || fem) begin
        for (int i = 0; i < NB; i++) actm[i] = bufm[i];
      end else begin
        actm[5] = actm[5] & 'h7f;
      end
    end
  end

  function automatic logic [NB*8-1:0] pack_model();
    logic [NB*8-1:0] v;
    for (int i = 0; i < NB; i++) v[i*8 +: 8] = actm[i][7:0];
    return v;
  endfunction

  always @(negedge sys_clk) begin
    if (started && !rst && !done) begin
      chk("R2 working copy vs model", active_o, pack_model());
      chk("R3 update pin pulse", {127'd0, upd_pin_o}, {127'd0, pinm});
      chk("R4 pin direction", {127'd0, upd_pin_oe}, {127'd0, actm[5][0]});
      chk("R8 clear1 output", {127'd0, clr_acc1_o}, {127'd0, actm[5][7] | actm[5][6]});
      chk("R9 clear2 output", {127'd0, clr_acc2_o}, {127'd0, actm[5][6]});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic host_wr(input int a, input int d);
    @(negedge hclk);
    h_we = 1'b1; h_addr = 5'(a); h_wdata = 8'(d);
    @(negedge hclk);
    h_we = 1'b0;
  endtask

  task automatic wait_upd();
    int n = 0;
    do begin
      @(negedge sys_clk);
      n++;
    end while (!upd_pin_o && n < 500);
  endtask

  task automatic ext_pulse();
    @(negedge sys_clk); upd_pin_i = 1'b1;
    repeat (4) @(negedge sys_clk);
    upd_pin_i = 1'b0;
    repeat (4) @(negedge sys_clk);
  endtask

  function automatic logic [NB*8-1:0] b(input int i);
    return {120'd0, active_o[i*8 +: 8]};
  endfunction

  // ---------------- directed sequence ----------------
  initial begin
    int gap, ones;
    logic [NB*8-1:0] expv;
    repeat (12) @(negedge sys_clk);
    rst = 1'b0;
    @(negedge sys_clk);
    // R6 defaults
    chk("R6 byte0", b(0), 'h40);
    chk("R6 byte4", b(4), 'h20);
    chk("R6 byte5", b(5), 'h01);
    chk("R6 byte6", b(6), 'h64);
    chk("R6 byte7", b(7), 'h10);
    chk("R6 start internal", {127'd0, upd_pin_oe}, 1);

    // R1 then R2
    host_wr(10, 'hA5);
    @(negedge sys_clk);
    chk("R1 byte10 held", b(10), 0);
    wait_upd();
    chk("R2 byte10 loaded", b(10), 'hA5);

    // R3 period 10
    host_wr(0, 9);
    wait_upd(); wait_upd(); wait_upd();
    gap = 0;
    do begin @(negedge sys_clk); gap++; end while (!upd_pin_o && gap < 200);
    chk("R3 period", gap, 10);

    // R8 one-shot
    host_wr(5, 'h81);
    wait_upd();
    ones = 0;
    for (int k = 0; k < 10; k++) begin
      if (clr_acc1_o) ones++;
      @(negedge sys_clk);
    end
    chk("R8 one pulse per update", ones, 1);
    wait_upd();
    chk("R8 repeats from host copy", {127'd0, clr_acc1_o}, 1);

    // R9 hold
    host_wr(5, 'h41);
    wait_upd();
    ones = 0;
    for (int k = 0; k < 9; k++) begin
      if (clr_acc1_o && clr_acc2_o) ones++;
      @(negedge sys_clk);
    end
    chk("R9 both clears held", ones, 9);

    // switch to external
    host_wr(5, 'h00);
    wait_upd();
    @(negedge sys_clk);
    chk("R4 external releases pin", {127'd0, upd_pin_oe}, 0);

    // R10 and R5
    host_wr(20, 'hFF);
    host_wr(11, 'h3C);
    @(negedge sys_clk); upd_pin_i = 1'b1;
    @(negedge sys_clk); @(negedge sys_clk);
    chk("R5 not before third edge", b(11), 0);
    @(negedge sys_clk);
    chk("R5 loaded at third edge", b(11), 'h3C);
    repeat (3) @(negedge sys_clk);
    upd_pin_i = 1'b0;
    repeat (3) @(negedge sys_clk);
    expv = '0;
    expv[0*8 +: 8] = 8'h09; expv[4*8 +: 8] = 8'h20; expv[6*8 +: 8] = 8'h64;
    expv[7*8 +: 8] = 8'h10; expv[10*8 +: 8] = 8'hA5; expv[11*8 +: 8] = 8'h3C;
    chk("R10 out-of-range write ignored", active_o, expv);

    // R11 writes while system clock stopped
    @(negedge sys_clk); clk_run = 1'b0;
    host_wr(12, 'h77);
    #20 clk_run = 1'b1;
    ext_pulse();
    chk("R11 write kept across stop", b(12), 'h77);

    // R7 staged mode change
    host_wr(5, 'h01);
    repeat (20) @(negedge sys_clk);
    chk("R7 mode not yet applied", {127'd0, upd_pin_oe}, 0);
    ext_pulse();
    chk("R7 mode applied after update", {127'd0, upd_pin_oe}, 1);
    wait_upd();
    gap = 0;
    do begin @(negedge sys_clk); gap++; end while (!upd_pin_o && gap < 200);
    chk("R3 period after return", gap, 10);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule